// File: doc/BRIEF.md
# Chopped Bang-Bang Loop Filter with Fractional Dither

This block is the digital heart of a frequency-locked oscillator loop. A comparator reports one bit per frame: whether the oscillator is fast or slow against the RC reference. The block takes that bit once per frame, on a single-cycle frame strobe. It undoes the comparator chopping by flipping the bit on alternate frames. It then moves a 16-bit tuning word one step up or down, and the word clamps at both ends instead of wrapping. The chop state is also sent out as an output, so the comparator inputs can be swapped in step with it. Over an even number of frames, a fixed comparator offset then cancels.

The tuning word has 13 integer bits and 3 fractional bits. The coarse oscillator accepts only the integer part. A first-order accumulator of the fraction, clocked at half the oscillator rate, adds its carry to the integer part on every half-rate cycle. This happens 16 times per frame. The time-averaged code therefore carries the fractional resolution, which makes the oscillator step at least eight times finer. The full tuning word is also available as an output, so the loop state can be observed.

The block runs entirely on the half-rate oscillator clock. The frame strobe is expected once every 16 of its cycles. A synchronous active-low reset loads a tuning word supplied from outside and empties the dither residue.

Top module: `fll_loop_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tune_word` takes `init_word`, `chop_sel` takes 0, `dco_code` takes `init_word[15:3]`, and the dither residue is set to zero.
- R2: On an edge where `ph5_stb` is low, neither `tune_word` nor `chop_sel` changes.
- R3: On a strobe edge with `chop_sel` at 0, a `cmp_bit` of 1 raises `tune_word` by one LSB and a `cmp_bit` of 0 lowers it by one LSB.
- R4: Every strobe edge inverts `chop_sel`. While `chop_sel` is 1, the comparator bit is inverted before it is applied: a 1 lowers the word and a 0 raises it.
- R5: A raise at `tune_word` = 16'hFFFF leaves it at 16'hFFFF.
- R6: A lower at `tune_word` = 0 leaves it at 0.
- R7: While `tune_word` is held, the sum of `dco_code` over any 8 consecutive edges equals 8 × `tune_word[15:3]` + `tune_word[2:0]`.
- R8: On each edge, `dco_code` becomes either the integer part `tune_word[15:3]` from before that edge or that value plus one. At integer part 8191 it stays at 8191.
- R9: After reset, with the word held at integer part I and fraction f, the k-th edge sets `dco_code` to I + floor(k·f/8) − floor((k−1)·f/8), limited to 8191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_word | input | 16 | Tuning word loaded during reset (13.3 fixed point) |
| ph5_stb | input | 1 | Single-cycle frame strobe, one per 16 clocks |
| cmp_bit | input | 1 | Comparator decision, 1 = raise (before chop) |
| tune_word | output | 16 | Accumulated tuning word, integer in [15:3], fraction in [2:0] |
| dco_code | output | 13 | Dithered integer oscillator code |
| chop_sel | output | 1 | Chop state; 1 means the comparator inputs are swapped |

## Verification
After a strobe sampled at edge n, `tune_word` and `chop_sel` carry the result from edge n onward. `dco_code` reflects that new word one edge later, at n+1, because the dither stage registers its code from the registered word. The bench drives inputs on falling edges and samples on the next falling edge, so each accumulator result is read one edge after its strobe. The modulator sweep counts edges from reset release and compares the k-th code with the closed-form carry sequence; no strobe falls inside that window.

// File: rtl/fll_pkg.sv
package fll_pkg;

    typedef enum logic {
        CHOP_DIRECT  = 1'b0,
        CHOP_SWAPPED = 1'b1
    } chop_e;

    // Direction after undoing the chop: 1 = raise, 0 = lower.
    function automatic logic unchop(input logic raw_bit, input chop_e state);
        return raw_bit ^ (state == CHOP_SWAPPED);
    endfunction

    function automatic chop_e chop_next(input chop_e state);
        return (state == CHOP_DIRECT) ? CHOP_SWAPPED : CHOP_DIRECT;
    endfunction

endpackage

// File: rtl/fll_chop_accum.sv
module fll_chop_accum
    import fll_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] init_word,
    input  logic              strobe,
    input  logic              cmp_bit,
    output logic [WORD_W-1:0] word_o,
    output logic              chop_o
);

    localparam logic [WORD_W-1:0] WORD_MAX = '1;
    localparam logic [WORD_W-1:0] WORD_MIN = '0;
    localparam logic [WORD_W-1:0] WORD_LSB = WORD_W'(1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        chop_e             chop;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic       raise;

    always_comb begin
        st_d  = st_q;
        raise = unchop(cmp_bit, st_q.chop);
        if (strobe) begin
            if (raise) begin
                if (st_q.word != WORD_MAX) begin
                    st_d.word = st_q.word + WORD_LSB;
                end
            end else begin
                if (st_q.word != WORD_MIN) begin
                    st_d.word = st_q.word - WORD_LSB;
                end
            end
            st_d.chop = chop_next(st_q.chop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.word <= init_word;
            st_q.chop <= CHOP_DIRECT;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;
    assign chop_o = (st_q.chop == CHOP_SWAPPED);

endmodule

// File: rtl/fll_frac_sdm.sv
module fll_frac_sdm #(
    parameter int INT_W  = 13,
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INT_W-1:0]  init_int,
    input  logic [INT_W-1:0]  int_in,
    input  logic [FRAC_W-1:0] frac_in,
    output logic [INT_W-1:0]  code_o
);

    localparam logic [INT_W-1:0] INT_MAX = '1;

    typedef struct packed {
        logic [FRAC_W-1:0] residue;
        logic [INT_W-1:0]  code;
    } sdm_state_t;

    sdm_state_t       st_d, st_q;
    logic [FRAC_W:0]  sum;
    logic             carry;

    always_comb begin
        st_d         = st_q;
        sum          = {1'b0, st_q.residue} + {1'b0, frac_in};
        carry        = sum[FRAC_W];
        st_d.residue = sum[FRAC_W-1:0];
        if (carry && (int_in == INT_MAX)) begin
            st_d.code = INT_MAX;
        end else begin
            st_d.code = int_in + INT_W'(carry);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.residue <= '0;
            st_q.code    <= init_int;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;

endmodule

// File: rtl/fll_loop_core.sv
module fll_loop_core #(
    parameter int INT_W  = 13,
    parameter int FRAC_W = 3,
    localparam int WORD_W = INT_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] init_word,
    input  logic              ph5_stb,
    input  logic              cmp_bit,
    output logic [WORD_W-1:0] tune_word,
    output logic [INT_W-1:0]  dco_code,
    output logic              chop_sel
);

    logic [WORD_W-1:0] word_w;

    fll_chop_accum #(
        .WORD_W (WORD_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_word (init_word),
        .strobe    (ph5_stb),
        .cmp_bit   (cmp_bit),
        .word_o    (word_w),
        .chop_o    (chop_sel)
    );

    fll_frac_sdm #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_sdm (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_int (init_word[WORD_W-1:FRAC_W]),
        .int_in   (word_w[WORD_W-1:FRAC_W]),
        .frac_in  (word_w[FRAC_W-1:0]),
        .code_o   (dco_code)
    );

    assign tune_word = word_w;

endmodule

// File: rtl/fll_loop_core_chk.sv
module fll_loop_core_chk #(
    parameter int INT_W  = 13,
    parameter int FRAC_W = 3,
    localparam int WORD_W = INT_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ph5_stb,
    input logic [WORD_W-1:0] tune_word,
    input logic [INT_W-1:0]  dco_code,
    input logic              chop_sel
);

    localparam logic [WORD_W-1:0] W_MAX = '1;
    localparam logic [WORD_W-1:0] W_ONE = WORD_W'(1);
    localparam logic [INT_W-1:0]  I_ONE = INT_W'(1);

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !ph5_stb |=> $stable(tune_word)); // R2
    AST_HOLD_CHOP: assert property (@(posedge clk) disable iff (!rst_n)
        !ph5_stb |=> $stable(chop_sel)); // R2
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ph5_stb |=> (tune_word == $past(tune_word) + W_ONE) || (tune_word == $past(tune_word) - W_ONE) || (tune_word == $past(tune_word))); // R3
    AST_CHOP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        ph5_stb |=> (chop_sel != $past(chop_sel))); // R4
    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ph5_stb && tune_word == W_MAX) |=> (tune_word == W_MAX || tune_word == W_MAX - W_ONE)); // R5
    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ph5_stb && tune_word == '0) |=> (tune_word == '0 || tune_word == W_ONE)); // R6
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dco_code == $past(tune_word[WORD_W-1:FRAC_W])) || (dco_code == $past(tune_word[WORD_W-1:FRAC_W]) + I_ONE)); // R8

endmodule

bind fll_loop_core fll_loop_core_chk #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph5_stb   (ph5_stb),
    .tune_word (tune_word),
    .dco_code  (dco_code),
    .chop_sel  (chop_sel)
);

// File: tb/tb_fll_loop_core.sv
module tb_fll_loop_core;

    localparam int INT_W  = 13;
    localparam int FRAC_W = 3;
    localparam int WORD_W = 16;
    localparam int WMAX   = 65535;
    localparam int IMAX   = 8191;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WORD_W-1:0] init_word = '0;
    logic              ph5_stb = 1'b0;
    logic              cmp_bit = 1'b0;
    logic [WORD_W-1:0] tune_word;
    logic [INT_W-1:0]  dco_code;
    logic              chop_sel;

    int n_chk  = 0;
    int n_fail = 0;
    int m_word = 0;
    int m_chop = 0;

    always #10 clk = ~clk;

    fll_loop_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_word (init_word),
        .ph5_stb   (ph5_stb),
        .cmp_bit   (cmp_bit),
        .tune_word (tune_word),
        .dco_code  (dco_code),
        .chop_sel  (chop_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int w);
        @(negedge clk);
        rst_n     = 1'b0;
        ph5_stb   = 1'b0;
        init_word = WORD_W'(w);
        @(negedge clk);
        rst_n  = 1'b1;
        m_word = w;
        m_chop = 0;
        check("R1 word", int'(tune_word), w);
        check("R1 chop", int'(chop_sel), 0);
        check("R1 code", int'(dco_code), w / 8);
    endtask

    task automatic strobe(input logic b);
        int up;
        @(negedge clk);
        ph5_stb = 1'b1;
        cmp_bit = b;
        @(negedge clk);
        ph5_stb = 1'b0;
        up = (int'(b) ^ m_chop);
        if (up == 1) m_word = (m_word == WMAX) ? WMAX : m_word + 1;
        else         m_word = (m_word == 0) ? 0 : m_word - 1;
        m_chop = 1 - m_chop;
        check("R3 word after strobe", int'(tune_word), m_word);
        check("R4 chop after strobe", int'(chop_sel), m_chop);
        @(negedge clk);
        @(negedge clk);
        check("R2 word held", int'(tune_word), m_word);
        check("R2 chop held", int'(chop_sel), m_chop);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int base_ints[3];
        base_ints[0] = 1000;
        base_ints[1] = 0;
        base_ints[2] = IMAX;

        // R7, R8, R9: sweep every fraction over three integer parts
        foreach (base_ints[bi]) begin
            for (int f = 0; f < 8; f++) begin
                int sum;
                int ip;
                ip  = base_ints[bi];
                sum = 0;
                do_reset(ip * 8 + f);
                for (int k = 1; k <= 16; k++) begin
                    int exp;
                    @(negedge clk);
                    exp = ip + (k * f) / 8 - ((k - 1) * f) / 8;
                    if (exp > IMAX) exp = IMAX;
                    if (ip == IMAX) check("R8 code capped", int'(dco_code), exp);
                    else            check("R9 code sequence", int'(dco_code), exp);
                    sum += int'(dco_code);
                    if (k == 8 && ip != IMAX) check("R7 eight-cycle mean", sum, 8 * ip + f);
                    if (k == 8) sum = 0;
                end
            end
        end

        // R3, R4: explicit chop directions
        do_reset(16'h1000);
        strobe(1'b1);
        check("R3 raise with chop 0", int'(tune_word), 16'h1001);
        strobe(1'b1);
        check("R4 bit 1 lowers with chop 1", int'(tune_word), 16'h1000);
        strobe(1'b0);
        check("R3 lower with chop 0", int'(tune_word), 16'h0FFF);
        strobe(1'b0);
        check("R4 bit 0 raises with chop 1", int'(tune_word), 16'h1000);

        // R2, R3, R4: pseudo-random decision stream
        begin
            logic [7:0] lfsr;
            lfsr = 8'hA5;
            for (int i = 0; i < 48; i++) begin
                strobe(lfsr[0]);
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            end
        end

        // R5: clamp at top
        do_reset(16'hFFFE);
        for (int i = 0; i < 4; i++) strobe(m_chop == 0 ? 1'b1 : 1'b0);
        check("R5 top clamp", int'(tune_word), WMAX);
        strobe(m_chop == 0 ? 1'b0 : 1'b1);
        check("R5 leave top", int'(tune_word), WMAX - 1);

        // R6: clamp at bottom
        do_reset(16'h0001);
        for (int i = 0; i < 4; i++) strobe(m_chop == 0 ? 1'b0 : 1'b1);
        check("R6 bottom clamp", int'(tune_word), 0);
        strobe(m_chop == 0 ? 1'b1 : 1'b0);
        check("R6 leave bottom", int'(tune_word), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule